// File: doc/BRIEF.md
# Converter Control Register and Sequencer

This block is the digital control core of a four-channel, twelve-bit converter. A host reaches it over an 8-bit parallel bus with chip select, write, read, register select and byte-select strobes. Through one status/control register it picks how the output data is presented, starts calibrations, enters and leaves a low-power state, and chooses what a shared pin does. That pin either requests a calibration while LOW, or acts as an edge trigger that moves the converter from sampling to holding and starts a conversion.

The analog parts (comparator, successive-approximation core, supply monitor) sit outside. The block pulses `cal_start` or `conv_start` to them and waits for `cal_done` (with an overflow flag) or `conv_done` (with the 12-bit code). While powered down, the block still runs a single conversion, or a calibration followed by a conversion, and then goes back to sleep. When the supply drops out and comes back, the block raises a sticky flag, clears the mode bits and forces a calibration. The converted code is presented once per conversion as a valid-only pulse (`result_valid`). There is no ready, because the analog core cannot be held off. The host reads the code from the bus at its own pace.

Top module: `adc_ctrl_core`

## Requirements
- R1: The register is written on a clock edge where `cs`, `wr`, `reg_sel` and `hbe` are all HIGH. A write with `reg_sel` HIGH and `hbe` LOW changes nothing.
- R2: With `cs` and `rd` HIGH, `reg_sel` HIGH and `hbe` HIGH, `rdata` shows the status byte: bit0 latch mode, bit1 calibrating, bit2 pin mode, bit3 powered down, bit4 zero, bit5 power fail, bit6 calibration overflow, bit7 busy. With `reg_sel` HIGH and `hbe` LOW, or with no read strobe, `rdata` is zero.
- R3: Writing bit1 HIGH while idle pulses `cal_start` in the cycle after the write edge. Bits 1 and 7 then read HIGH until the edge where `cal_done` is seen. Bit6 takes the `cal_ovf` value sampled with `cal_done`.
- R4: With bit2 LOW, `trig_pin` is synchronised by two flops. A LOW level on it starts a calibration, with `cal_start` HIGH after the third clock edge following the pin going LOW.
- R5: With bit2 HIGH, a rising edge on `trig_pin` starts a conversion, with `conv_start` HIGH after the third clock edge following the rise. A LOW level on the pin in this mode starts no calibration.
- R6: In trigger mode, a rise that follows fewer than `LOW_MIN` synchronised LOW cycles starts nothing. It sets `trig_viol`, which stays HIGH until the next register write.
- R7: Writing bit3 HIGH (bit1 LOW) while idle enters power-down: `power_down` goes HIGH and bit3 reads HIGH. Power-down is left by a register write with bits 1 and 3 LOW, or by a calibration request from bit1 or from the pin.
- R8: While powered down, a write with `reg_sel` LOW runs one conversion. During it bit3 reads HIGH and `power_down` is LOW. After `conv_done`, the block returns to power-down.
- R9: Writing bits 1 and 3 together runs one calibration, then one conversion, then settles in power-down.
- R10: `supply_low` HIGH sets bit5. Its fall forces a calibration (`cal_start` after the next edge, even when busy) and clears bits 0, 2 and 3. Writing bit5 LOW clears it and writing it HIGH does not set it.
- R11: While busy, calibration, conversion and power-down requests are ignored.
- R12: A write with `reg_sel` LOW while idle starts a conversion. On `conv_done` the code is stored and `result_valid` pulses. A read with `reg_sel` LOW returns the low byte (`hbe` LOW) or the high nibble (`hbe` HIGH). The value is `conv_data` live when bit0 is LOW, and the stored code when bit0 is HIGH.
- R13: Bit4 is discarded on write and always reads LOW.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cs | input | 1 | Chip select |
| wr | input | 1 | Write strobe |
| rd | input | 1 | Read strobe |
| reg_sel | input | 1 | HIGH selects the control register, LOW the output data |
| hbe | input | 1 | Byte select |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data |
| trig_pin | input | 1 | Shared calibration-request / sample trigger pin (asynchronous) |
| supply_low | input | 1 | Supply monitor dropout indication |
| cal_done | input | 1 | Calibration finished |
| cal_ovf | input | 1 | Overflow during the finished calibration |
| conv_done | input | 1 | Conversion finished |
| conv_data | input | 12 | Code from the converter core |
| cal_start | output | 1 | One-cycle calibration start |
| conv_start | output | 1 | One-cycle conversion start |
| power_down | output | 1 | Analog sections switched off |
| trig_viol | output | 1 | Sticky early-trigger flag |
| result_valid | output | 1 | One-cycle pulse when a new code is stored |

## Verification
The hardest states to reach are those that depend on history the bus cannot set directly. One is a trigger rise judged against the length of the preceding LOW run. Another is a supply recovery that lands while the block is powered down with mode bits set. The stimulus reaches the first by holding the pin LOW for counted clock runs on either side of `LOW_MIN`, then timing the rise. It reaches the second by entering power-down with latch mode set, then toggling `supply_low`. A behavioural core model answers every start pulse after a set latency, which lets a test stretch a calibration long enough to fire competing requests inside it.

// File: rtl/adc_ctrl_pkg.sv
package adc_ctrl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_CAL     = 3'd1,
    ST_CONV    = 3'd2,
    ST_PD      = 3'd3,
    ST_PD_CAL  = 3'd4,
    ST_PD_CONV = 3'd5
  } seq_state_t;

  // status / control byte positions
  localparam int unsigned B_LATCH = 0;
  localparam int unsigned B_CAL   = 1;
  localparam int unsigned B_PMODE = 2;
  localparam int unsigned B_PD    = 3;
  localparam int unsigned B_RSVD  = 4;
  localparam int unsigned B_PF    = 5;
  localparam int unsigned B_OVF   = 6;
  localparam int unsigned B_BUSY  = 7;

  typedef struct packed {
    logic cal;      // calibrate, stay awake
    logic cal_pd;   // calibrate + convert, then sleep
    logic pd_on;    // enter power-down
    logic pd_off;   // leave power-down
    logic pin_cal;  // level request from shared pin
    logic conv_wr;  // conversion request from bus
    logic trig;     // conversion request from pin edge
    logic recover;  // supply came back
  } seq_req_t;

endpackage

// File: rtl/adc_pin_sync.sv
module adc_pin_sync #(
  parameter int unsigned LOW_MIN = 500
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_async,
  input  logic trig_mode,
  output logic pin_low,
  output logic trig_ok,
  output logic trig_early
);
  localparam int unsigned CNT_W = $clog2(LOW_MIN + 1);

  logic s1, s2, s3;
  logic [CNT_W-1:0] low_cnt;
  logic rise;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= 1'b1;
      s2 <= 1'b1;
      s3 <= 1'b1;
    end else begin
      s1 <= pin_async;
      s2 <= s1;
      s3 <= s2;
    end
  end

  // length of the current / just-ended LOW run, saturating
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_cnt <= '0;
    end else if (s2) begin
      low_cnt <= '0;
    end else if (low_cnt != CNT_W'(LOW_MIN)) begin
      low_cnt <= low_cnt + 1'b1;
    end
  end

  assign rise       = s2 & ~s3;
  assign pin_low    = ~s2;
  assign trig_ok    = trig_mode & rise & (low_cnt >= CNT_W'(LOW_MIN));
  assign trig_early = trig_mode & rise & (low_cnt <  CNT_W'(LOW_MIN));

endmodule

// File: rtl/adc_sfr.sv
module adc_sfr (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_en,
  input  logic wd_latch,
  input  logic wd_pmode,
  input  logic wd_pf,
  input  logic recover,
  input  logic supply_low,
  input  logic cal_fin,
  input  logic cal_ovf,
  input  logic trig_early,
  output logic latch_mode,
  output logic pin_mode,
  output logic pf_flag,
  output logic ovf_flag,
  output logic viol_flag
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      latch_mode <= 1'b0;
      pin_mode   <= 1'b0;
    end else if (recover) begin
      latch_mode <= 1'b0;
      pin_mode   <= 1'b0;
    end else if (wr_en) begin
      latch_mode <= wd_latch;
      pin_mode   <= wd_pmode;
    end
  end

  // sticky power-fail: only a LOW write clears it
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                pf_flag <= 1'b0;
    else if (supply_low)       pf_flag <= 1'b1;
    else if (wr_en && !wd_pf)  pf_flag <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ovf_flag <= 1'b0;
    else if (cal_fin) ovf_flag <= cal_ovf;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          viol_flag <= 1'b0;
    else if (trig_early) viol_flag <= 1'b1;
    else if (wr_en)      viol_flag <= 1'b0;
  end

endmodule

// File: rtl/adc_seq.sv
module adc_seq
  import adc_ctrl_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  seq_req_t req,
  input  logic     cal_done,
  input  logic     conv_done,
  output logic     cal_start,
  output logic     conv_start,
  output logic     busy,
  output logic     calibrating,
  output logic     converting,
  output logic     in_pd,
  output logic     sleeping
);
  seq_state_t state, nxt;
  logic go_cal, go_conv;

  always_comb begin
    nxt     = state;
    go_cal  = 1'b0;
    go_conv = 1'b0;
    if (req.recover) begin
      nxt    = ST_CAL;
      go_cal = 1'b1;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (req.cal_pd) begin
            nxt = ST_PD_CAL; go_cal = 1'b1;
          end else if (req.cal || req.pin_cal) begin
            nxt = ST_CAL; go_cal = 1'b1;
          end else if (req.conv_wr || req.trig) begin
            nxt = ST_CONV; go_conv = 1'b1;
          end else if (req.pd_on) begin
            nxt = ST_PD;
          end
        end
        ST_PD: begin
          if (req.cal_pd) begin
            nxt = ST_PD_CAL; go_cal = 1'b1;
          end else if (req.cal || req.pin_cal) begin
            nxt = ST_CAL; go_cal = 1'b1;
          end else if (req.pd_off) begin
            nxt = ST_IDLE;
          end else if (req.conv_wr) begin
            nxt = ST_PD_CONV; go_conv = 1'b1;
          end
        end
        ST_CAL:     if (cal_done)  nxt = ST_IDLE;
        ST_CONV:    if (conv_done) nxt = ST_IDLE;
        ST_PD_CAL:  if (cal_done) begin
                      nxt = ST_PD_CONV; go_conv = 1'b1;
                    end
        ST_PD_CONV: if (conv_done) nxt = ST_PD;
        default:    nxt = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      cal_start  <= 1'b0;
      conv_start <= 1'b0;
    end else begin
      state      <= nxt;
      cal_start  <= go_cal;
      conv_start <= go_conv;
    end
  end

  assign calibrating = (state == ST_CAL)  || (state == ST_PD_CAL);
  assign converting  = (state == ST_CONV) || (state == ST_PD_CONV);
  assign busy        = calibrating || converting;
  assign in_pd       = (state == ST_PD) || (state == ST_PD_CAL) || (state == ST_PD_CONV);
  assign sleeping    = (state == ST_PD);

endmodule

// File: rtl/adc_ctrl_core.sv
module adc_ctrl_core
  import adc_ctrl_pkg::*;
#(
  parameter int unsigned BUS_W   = 8,
  parameter int unsigned DATA_W  = 12,
  parameter int unsigned LOW_MIN = 500
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs,
  input  logic              wr,
  input  logic              rd,
  input  logic              reg_sel,
  input  logic              hbe,
  input  logic [BUS_W-1:0]  wdata,
  output logic [BUS_W-1:0]  rdata,
  input  logic              trig_pin,
  input  logic              supply_low,
  input  logic              cal_done,
  input  logic              cal_ovf,
  input  logic              conv_done,
  input  logic [DATA_W-1:0] conv_data,
  output logic              cal_start,
  output logic              conv_start,
  output logic              power_down,
  output logic              trig_viol,
  output logic              result_valid
);
  localparam int unsigned WIDE_W = 2 * BUS_W;

  logic sfr_wr, data_wr, sup_q, recover;
  logic latch_mode, pin_mode, pf_flag, ovf_flag;
  logic pin_low, trig_ok, trig_early;
  logic busy, calibrating, converting, in_pd;
  logic [DATA_W-1:0] result_q, dout;
  logic [WIDE_W-1:0] dout_ext;
  logic [BUS_W-1:0]  status;
  seq_req_t          req;
  logic              unused_wbits;

  assign sfr_wr  = cs & wr & reg_sel & hbe;
  assign data_wr = cs & wr & ~reg_sel;
  assign unused_wbits = ^{wdata[BUS_W-1:B_OVF], wdata[B_RSVD]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sup_q <= 1'b0;
    else        sup_q <= supply_low;
  end
  assign recover = sup_q & ~supply_low;

  adc_pin_sync #(.LOW_MIN(LOW_MIN)) u_pin (
    .clk        (clk),
    .rst_n      (rst_n),
    .pin_async  (trig_pin),
    .trig_mode  (pin_mode),
    .pin_low    (pin_low),
    .trig_ok    (trig_ok),
    .trig_early (trig_early)
  );

  adc_sfr u_sfr (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (sfr_wr),
    .wd_latch   (wdata[B_LATCH]),
    .wd_pmode   (wdata[B_PMODE]),
    .wd_pf      (wdata[B_PF]),
    .recover    (recover),
    .supply_low (supply_low),
    .cal_fin    (cal_done & calibrating),
    .cal_ovf    (cal_ovf),
    .trig_early (trig_early),
    .latch_mode (latch_mode),
    .pin_mode   (pin_mode),
    .pf_flag    (pf_flag),
    .ovf_flag   (ovf_flag),
    .viol_flag  (trig_viol)
  );

  always_comb begin
    req         = '0;
    req.cal     = sfr_wr &  wdata[B_CAL] & ~wdata[B_PD];
    req.cal_pd  = sfr_wr &  wdata[B_CAL] &  wdata[B_PD];
    req.pd_on   = sfr_wr & ~wdata[B_CAL] &  wdata[B_PD];
    req.pd_off  = sfr_wr & ~wdata[B_CAL] & ~wdata[B_PD];
    req.pin_cal = ~pin_mode & pin_low;
    req.conv_wr = data_wr;
    req.trig    = trig_ok;
    req.recover = recover;
  end

  adc_seq u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .req         (req),
    .cal_done    (cal_done),
    .conv_done   (conv_done),
    .cal_start   (cal_start),
    .conv_start  (conv_start),
    .busy        (busy),
    .calibrating (calibrating),
    .converting  (converting),
    .in_pd       (in_pd),
    .sleeping    (power_down)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      result_q     <= '0;
      result_valid <= 1'b0;
    end else begin
      result_valid <= conv_done & converting;
      if (conv_done && converting) result_q <= conv_data;
    end
  end

  assign dout     = latch_mode ? result_q : conv_data;
  assign dout_ext = WIDE_W'(dout);

  always_comb begin
    status          = '0;
    status[B_LATCH] = latch_mode;
    status[B_CAL]   = calibrating;
    status[B_PMODE] = pin_mode;
    status[B_PD]    = in_pd;
    status[B_PF]    = pf_flag;
    status[B_OVF]   = ovf_flag;
    status[B_BUSY]  = busy;
  end

  always_comb begin
    rdata = '0;
    if (cs && rd) begin
      if (reg_sel) rdata = hbe ? status : '0;
      else         rdata = hbe ? dout_ext[WIDE_W-1:BUS_W] : dout_ext[BUS_W-1:0];
    end
  end

endmodule

// File: rtl/adc_ctrl_chk.sv
module adc_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cs,
  input logic       wr,
  input logic       rd,
  input logic       reg_sel,
  input logic       hbe,
  input logic [7:0] rdata,
  input logic       cal_start,
  input logic       conv_start,
  input logic       power_down,
  input logic       result_valid,
  input logic       conv_done,
  input logic       busy,
  input logic       recover,
  input logic       latch_mode,
  input logic       pin_mode
);

  // R1
  reserved_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cs && wr && reg_sel && !hbe && !recover) |=> ($stable(latch_mode) && $stable(pin_mode)));

  // R2
  reserved_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cs && rd && reg_sel && !hbe) |-> (rdata == 8'h00));

  // R11
  busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !recover) |=> !cal_start);

  // R10
  recover_cal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    recover |=> cal_start);

  // R8
  sleep_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    power_down |-> !busy);

  // R9
  single_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cal_start, conv_start}));

  // R12
  result_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    result_valid |-> $past(conv_done));

endmodule

bind adc_ctrl_core adc_ctrl_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .cs           (cs),
  .wr           (wr),
  .rd           (rd),
  .reg_sel      (reg_sel),
  .hbe          (hbe),
  .rdata        (rdata),
  .cal_start    (cal_start),
  .conv_start   (conv_start),
  .power_down   (power_down),
  .result_valid (result_valid),
  .conv_done    (conv_done),
  .busy         (busy),
  .recover      (recover),
  .latch_mode   (latch_mode),
  .pin_mode     (pin_mode)
);

// File: tb/adc_ctrl_core_test.sv
`timescale 1ns/1ps
module adc_ctrl_core_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs = 0, wr = 0, rd = 0, reg_sel = 0, hbe = 0;
  logic [7:0] wdata = 0;
  logic [7:0] rdata;
  logic trig_pin = 1'b1, supply_low = 1'b0;
  logic cal_done = 0, cal_ovf = 0, conv_done = 0;
  logic [11:0] conv_data = 12'h000;
  logic cal_start, conv_start, power_down, trig_viol, result_valid;

  int checks = 0, fails = 0;
  int cal_lat = 20, conv_lat = 10;
  int cal_cnt = 0, conv_cnt = 0;
  logic ovf_val = 1'b0;
  int ncal = 0, nconv = 0, nres = 0;

  always #2.5 clk = ~clk;

  adc_ctrl_core uut (
    .clk(clk), .rst_n(rst_n), .cs(cs), .wr(wr), .rd(rd), .reg_sel(reg_sel),
    .hbe(hbe), .wdata(wdata), .rdata(rdata), .trig_pin(trig_pin),
    .supply_low(supply_low), .cal_done(cal_done), .cal_ovf(cal_ovf),
    .conv_done(conv_done), .conv_data(conv_data), .cal_start(cal_start),
    .conv_start(conv_start), .power_down(power_down), .trig_viol(trig_viol),
    .result_valid(result_valid)
  );

  // behavioural analog core
  always @(negedge clk) begin
    cal_done  = 1'b0;
    conv_done = 1'b0;
    if (cal_start) cal_cnt = cal_lat;
    else if (cal_cnt > 0) begin
      cal_cnt--;
      if (cal_cnt == 0) begin cal_done = 1'b1; cal_ovf = ovf_val; end
    end
    if (conv_start) conv_cnt = conv_lat;
    else if (conv_cnt > 0) begin
      conv_cnt--;
      if (conv_cnt == 0) conv_done = 1'b1;
    end
  end

  always @(negedge clk) begin
    if (cal_start) ncal++;
    if (conv_start) nconv++;
    if (result_valid) nres++;
  end

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sfr_wr(logic [7:0] d);
    @(negedge clk);
    cs = 1; wr = 1; reg_sel = 1; hbe = 1; wdata = d;
    @(negedge clk);
    cs = 0; wr = 0; reg_sel = 0; hbe = 0; wdata = 0;
  endtask

  task automatic bus_wr(logic sel, logic hb, logic [7:0] d);
    @(negedge clk);
    cs = 1; wr = 1; reg_sel = sel; hbe = hb; wdata = d;
    @(negedge clk);
    cs = 0; wr = 0; reg_sel = 0; hbe = 0; wdata = 0;
  endtask

  task automatic bus_rd(logic sel, logic hb, output logic [7:0] d);
    cs = 1; rd = 1; reg_sel = sel; hbe = hb;
    #1 d = rdata;
    cs = 0; rd = 0; reg_sel = 0; hbe = 0;
  endtask

  task automatic status(output logic [7:0] d);
    bus_rd(1'b1, 1'b1, d);
  endtask

  task automatic wait_idle();
    logic [7:0] s;
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      status(s);
      if (!s[7]) return;
    end
  endtask

  task automatic t_reset();
    logic [7:0] s;
    status(s);
    check("R2 reset status", s, 8'h00);
    check("R7 reset power_down", power_down, 0);
    check("R2 no strobe rdata", rdata, 8'h00);
  endtask

  task automatic t_cal();
    logic [7:0] s;
    ovf_val = 1'b1;
    sfr_wr(8'h02);
    check("R3 cal_start after write", cal_start, 1);
    status(s);
    check("R3 calibrating+busy", s, 8'h82);
    wait_idle();
    status(s);
    check("R3 ovf captured", s, 8'h40);
    ovf_val = 1'b0;
    sfr_wr(8'h02);
    wait_idle();
    status(s);
    check("R3 ovf cleared by clean cal", s, 8'h00);
  endtask

  task automatic t_pin_cal();
    int c0;
    c0 = ncal;
    @(negedge clk); trig_pin = 0;
    cyc(2);
    check("R4 no cal after 2 edges", cal_start, 0);
    cyc(1);
    check("R4 cal_start after 3 edges", cal_start, 1);
    trig_pin = 1;
    wait_idle();
    check("R4 one calibration", ncal - c0, 1);
  endtask

  task automatic t_trigger();
    logic [7:0] s;
    int c0;
    sfr_wr(8'h04);
    c0 = ncal;
    @(negedge clk); trig_pin = 0;
    cyc(600);
    status(s);
    check("R5 low level no cal in trigger mode", s, 8'h04);
    check("R5 cal count", ncal - c0, 0);
    trig_pin = 1;
    cyc(2);
    check("R5 no conv after 2 edges", conv_start, 0);
    cyc(1);
    check("R5 conv_start after 3 edges", conv_start, 1);
    check("R6 no viol on long low", trig_viol, 0);
    wait_idle();
    c0 = nconv;
    @(negedge clk); trig_pin = 0;
    cyc(100);
    trig_pin = 1;
    cyc(3);
    check("R6 early edge no conv", conv_start, 0);
    cyc(1);
    check("R6 viol set", trig_viol, 1);
    cyc(20);
    check("R6 early edge conv count", nconv - c0, 0);
    sfr_wr(8'h00);
    check("R6 viol cleared by write", trig_viol, 0);
  endtask

  task automatic t_pd();
    logic [7:0] s;
    sfr_wr(8'h08);
    check("R7 power_down entered", power_down, 1);
    status(s);
    check("R7 bit3 reads high", s, 8'h08);
    sfr_wr(8'h00);
    status(s);
    check("R7 exit by write low", s, 8'h00);
    sfr_wr(8'h08);
    @(negedge clk); trig_pin = 0;
    cyc(3);
    check("R7 pin cal exits power-down", cal_start, 1);
    check("R7 power_down low", power_down, 0);
    trig_pin = 1;
    wait_idle();
    status(s);
    check("R7 awake after pin cal", s, 8'h00);
  endtask

  task automatic t_pd_conv();
    logic [7:0] s;
    int c0;
    sfr_wr(8'h08);
    c0 = nconv;
    bus_wr(1'b0, 1'b0, 8'h00);
    check("R8 conv_start in power-down", conv_start, 1);
    check("R8 power_down low during conv", power_down, 0);
    status(s);
    check("R8 bit3 and busy", s, 8'h88);
    wait_idle();
    check("R8 back to power-down", power_down, 1);
    check("R8 one conversion", nconv - c0, 1);
  endtask

  task automatic t_pd_calconv();
    logic [7:0] s;
    int c0, v0;
    c0 = ncal; v0 = nconv;
    sfr_wr(8'h0A);
    check("R9 cal_start", cal_start, 1);
    wait_idle();
    check("R9 calibrations", ncal - c0, 1);
    check("R9 conversions", nconv - v0, 1);
    check("R9 power_down after", power_down, 1);
    status(s);
    check("R9 status", s, 8'h08);
    sfr_wr(8'h00);
  endtask

  task automatic t_supply();
    logic [7:0] s;
    sfr_wr(8'h09);
    @(negedge clk); supply_low = 1;
    cyc(1);
    status(s);
    check("R10 pf set", s, 8'h29);
    supply_low = 0;
    cyc(1);
    check("R10 forced cal", cal_start, 1);
    wait_idle();
    status(s);
    check("R10 bits cleared pf kept", s, 8'h20);
    sfr_wr(8'h20);
    status(s);
    check("R10 pf high write keeps", s, 8'h20);
    sfr_wr(8'h00);
    status(s);
    check("R10 pf cleared", s, 8'h00);
  endtask

  task automatic t_busy();
    int c0, v0;
    cal_lat = 200;
    c0 = ncal; v0 = nconv;
    sfr_wr(8'h02);
    bus_wr(1'b0, 1'b0, 8'h00);
    sfr_wr(8'h08);
    @(negedge clk); trig_pin = 0;
    cyc(5);
    trig_pin = 1;
    wait_idle();
    check("R11 cal count", ncal - c0, 1);
    check("R11 conv count", nconv - v0, 0);
    check("R11 no power-down", power_down, 0);
    cal_lat = 20;
  endtask

  task automatic t_result();
    logic [7:0] d;
    int r0;
    @(negedge clk); conv_data = 12'hABC;
    bus_rd(1'b0, 1'b0, d);
    check("R12 transparent low", d, 8'hBC);
    bus_rd(1'b0, 1'b1, d);
    check("R12 transparent high", d, 8'h0A);
    sfr_wr(8'h01);
    conv_data = 12'h5A7;
    r0 = nres;
    bus_wr(1'b0, 1'b0, 8'h00);
    check("R12 conv_start from idle", conv_start, 1);
    wait_idle();
    cyc(2);
    check("R12 result_valid pulse", nres - r0, 1);
    conv_data = 12'hFFF;
    bus_rd(1'b0, 1'b0, d);
    check("R12 latched low", d, 8'hA7);
    bus_rd(1'b0, 1'b1, d);
    check("R12 latched high", d, 8'h05);
    sfr_wr(8'h00);
    bus_rd(1'b0, 1'b0, d);
    check("R12 back to transparent", d, 8'hFF);
  endtask

  task automatic t_decode();
    logic [7:0] s;
    bus_wr(1'b1, 1'b0, 8'h0D);
    status(s);
    check("R1 reserved write ignored", s, 8'h00);
    check("R1 no power-down", power_down, 0);
    bus_rd(1'b1, 1'b0, s);
    check("R2 reserved read zero", s, 8'h00);
    sfr_wr(8'h15);
    status(s);
    check("R13 bit4 reads low", s, 8'h05);
    sfr_wr(8'h00);
  endtask

  initial begin
    #750000;
    fails++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    cyc(5);
    rst_n = 1'b1;
    cyc(2);
    t_reset();
    t_cal();
    t_pin_cal();
    t_trigger();
    t_pd();
    t_pd_conv();
    t_pd_calconv();
    t_supply();
    t_busy();
    t_result();
    t_decode();
    cyc(5);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule